// File: doc/BRIEF.md
# Serial Code Entry Comparator with Multiplexed Display

This block takes a five-bit code that a user keys in one bit at a time. A level input carries the bit value. A trigger input tells the block to take that value. The block sees only the rising edge of the trigger, so one press stores one bit. While the code is being entered the display stays dark.

When the fifth bit arrives, the block compares the whole entry with a fixed code given as a parameter. It then lights six of seven seven-segment digits. Each of the first five digits shows one entered bit as '0' or '1'. The sixth digit shows 'E' when the entry matches the fixed code and 'n' when it does not. The seventh digit stays blank.

The digits are time-multiplexed: one digit-select output is active on each clock cycle, in turn. The picture stays lit for a fixed number of cycles; the default is 5000 cycles, which is five seconds at a 1 kHz clock. After that the block blanks the display and is ready for a new entry. Triggers that arrive while the result is shown are ignored.

Top module: `code_cmp_top`

## Requirements
- R1: While reset is asserted, and on the cycles after reset is released, every digit select `digitSel` is high (inactive) and `seg` reads 7'h7F (all segments off). Reset also discards any partial entry.
- R2: While fewer than five bits have been captured since the last blanking or reset, the display stays dark: `digitSel` is 7'h7F and `seg` is 7'h7F.
- R3: A bit is captured from `dataBit` on the clock edge where `trigger` is high and was low on the previous edge. The first bit captured shows on digit 1 (`digitSel[0]`) and the fifth on digit 5 (`digitSel[4]`). A 0 shows as 7'h40 and a 1 as 7'h79. The segment order is `seg[6:0]` = {g,f,e,d,c,b,a}, and a segment is lit when its bit is low.
- R4: Digit 6 (`digitSel[5]`) shows 'E' (7'h06) when the five bits, first bit as most significant, equal `STORED_CODE` (default 5'b11001). Otherwise it shows 'n' (7'h2B).
- R5: Digit 7 (`digitSel[6]`) is selected in turn but always shows 7'h7F.
- R6: While the result is shown, exactly one `digitSel` bit is low on each cycle. The active digit steps from digit 1 to digit 7 and then wraps back to digit 1.
- R7: The result stays lit for exactly `HOLD_CYCLES` clock cycles, counted from the edge that captured the fifth bit. After that the display is dark.
- R8: Trigger edges that arrive while the result is shown are ignored. After blanking, a new entry again needs five triggers.
- R9: A trigger held high for many cycles captures only one bit.
- R10: Asserting reset while the result is shown blanks the display at once. A complete new entry after reset then shows correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; it also sets the digit scan rate |
| rst | input | 1 | Synchronous reset, active high |
| dataBit | input | 1 | Level of the bit to be entered |
| trigger | input | 1 | Capture request; its rising edge takes one bit |
| digitSel | output | 7 | Digit selects, active low; bit i drives digit i+1 |
| seg | output | 7 | Segments {g,f,e,d,c,b,a}, active low |

## Verification
Assertions inside the RTL check on every cycle:
- the display is dark whenever no result is shown;
- exactly one digit is selected while the result is lit, and the scan advances in order;
- the seventh digit is always blank;
- the bit counter and hold counter stay in range;
- no bit is captured during the hold.

Only the bench scenarios can show the rest:
- that each digit carries the right glyph for the entered code, and that the 'E' or 'n' choice is right;
- the exact length of the hold;
- that presses during the hold or a long press do not shift the bit count of the next entry;
- that reset in the middle of an entry or during the hold restarts entry cleanly.

// File: rtl/code_cmp_pkg.sv
package code_cmp_pkg;

  localparam int SEG_W = 7;

  // Segment glyphs, bit order {g,f,e,d,c,b,a}, active low
  localparam logic [SEG_W-1:0] GLYPH_ZERO  = 7'h40;
  localparam logic [SEG_W-1:0] GLYPH_ONE   = 7'h79;
  localparam logic [SEG_W-1:0] GLYPH_EQUAL = 7'h06;
  localparam logic [SEG_W-1:0] GLYPH_DIFF  = 7'h2B;
  localparam logic [SEG_W-1:0] GLYPH_BLANK = 7'h7F;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // shift dataBit into the entry register
    logic clear;    // hold finished: drop the entry
    logic show;     // result is on display
  } ctrl_t;

endpackage

// File: rtl/code_cmp_ctrl.sv
module code_cmp_ctrl
  import code_cmp_pkg::*;
#(
  parameter int CODE_BITS   = 5,
  parameter int HOLD_CYCLES = 5000
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  trigIn,
  output ctrl_t strobe
);

  localparam int CNT_W  = $clog2(CODE_BITS);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  typedef enum logic {ST_COLLECT, ST_HOLD} state_t;

  state_t            state;
  logic              trigPrev;
  logic              trigRise;
  logic [CNT_W-1:0]  bitCount;
  logic [HOLD_W-1:0] holdCnt;
  logic              lastBit;
  logic              holdDone;

  assign trigRise = trigIn & ~trigPrev;
  assign lastBit  = (bitCount == CNT_W'(CODE_BITS - 1));
  assign holdDone = (holdCnt == HOLD_W'(HOLD_CYCLES - 1));

  always_comb begin
    strobe.capture = (state == ST_COLLECT) && trigRise;
    strobe.clear   = (state == ST_HOLD) && holdDone;
    strobe.show    = (state == ST_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trigPrev <= 1'b0;
      state    <= ST_COLLECT;
      bitCount <= '0;
      holdCnt  <= '0;
    end else begin
      trigPrev <= trigIn;
      case (state)
        ST_COLLECT: begin
          if (trigRise) begin
            if (lastBit) begin
              bitCount <= '0;
              holdCnt  <= '0;
              state    <= ST_HOLD;
            end else begin
              bitCount <= bitCount + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (holdDone) begin
            holdCnt <= '0;
            state   <= ST_COLLECT;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  AST_BITCOUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bitCount < CNT_W'(CODE_BITS)); // R2

  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (rst)
    holdCnt < HOLD_W'(HOLD_CYCLES)); // R7

  AST_NO_CAPTURE_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    strobe.show |-> !strobe.capture); // R8

  AST_FIFTH_STARTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && lastBit) |=> strobe.show); // R3

  AST_ONE_PER_PRESS: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> !strobe.capture); // R9

endmodule

// File: rtl/code_cmp_datapath.sv
module code_cmp_datapath
  import code_cmp_pkg::*;
#(
  parameter int                   CODE_BITS   = 5,
  parameter logic [CODE_BITS-1:0] STORED_CODE = 5'b11001
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dataBit,
  input  ctrl_t                  strobe,
  output logic [CODE_BITS+1:0]   digitSel,
  output logic [SEG_W-1:0]       seg
);

  localparam int NUM_DIGITS = CODE_BITS + 2;
  localparam int SCAN_W     = $clog2(NUM_DIGITS);
  localparam int RESULT_IDX = CODE_BITS;
  localparam int LAST_IDX   = NUM_DIGITS - 1;

  logic [CODE_BITS-1:0] entryReg;
  logic [SCAN_W-1:0]    scanIdx;
  logic                 isMatch;
  logic [SEG_W-1:0]     digitGlyph [NUM_DIGITS];

  assign isMatch = (entryReg == STORED_CODE);

  // The first bit entered sits in the MSB and lands on digit 1
  for (genvar d = 0; d < CODE_BITS; d++) begin : g_bitDigit
    assign digitGlyph[d] = entryReg[CODE_BITS-1-d] ? GLYPH_ONE : GLYPH_ZERO;
  end
  assign digitGlyph[RESULT_IDX] = isMatch ? GLYPH_EQUAL : GLYPH_DIFF;
  assign digitGlyph[LAST_IDX]   = GLYPH_BLANK;

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      entryReg <= '0;
    end else if (strobe.capture) begin
      entryReg <= {entryReg[CODE_BITS-2:0], dataBit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe.show) begin
      scanIdx <= '0;
    end else if (scanIdx == SCAN_W'(LAST_IDX)) begin
      scanIdx <= '0;
    end else begin
      scanIdx <= scanIdx + 1'b1;
    end
  end

  always_comb begin
    if (strobe.show) begin
      digitSel = ~(NUM_DIGITS'(1) << scanIdx);
      seg      = digitGlyph[scanIdx];
    end else begin
      digitSel = '1;
      seg      = GLYPH_BLANK;
    end
  end

  AST_DARK_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobe.show |-> (digitSel == '1 && seg == GLYPH_BLANK)); // R2

  AST_ONE_DIGIT_LIT: assert property (@(posedge clk) disable iff (rst)
    strobe.show |-> ($countones(~digitSel) == 1)); // R6

  AST_SCAN_STEPS: assert property (@(posedge clk) disable iff (rst)
    (strobe.show && scanIdx != SCAN_W'(LAST_IDX)) |=>
      (!strobe.show || scanIdx == $past(scanIdx) + 1'b1)); // R6

  AST_LAST_DIGIT_BLANK: assert property (@(posedge clk) disable iff (rst)
    !digitSel[LAST_IDX] |-> seg == GLYPH_BLANK); // R5

  AST_HOLD_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (strobe.show && $past(strobe.show)) |-> $stable(entryReg)); // R8

endmodule

// File: rtl/code_cmp_top.sv
module code_cmp_top
  import code_cmp_pkg::*;
#(
  parameter int                   CODE_BITS   = 5,
  parameter logic [CODE_BITS-1:0] STORED_CODE = 5'b11001,
  parameter int                   HOLD_CYCLES = 5000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dataBit,
  input  logic                 trigger,
  output logic [CODE_BITS+1:0] digitSel,
  output logic [SEG_W-1:0]     seg
);

  ctrl_t strobe;

  code_cmp_ctrl #(
    .CODE_BITS   (CODE_BITS),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .trigIn (trigger),
    .strobe (strobe)
  );

  code_cmp_datapath #(
    .CODE_BITS   (CODE_BITS),
    .STORED_CODE (STORED_CODE)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .dataBit  (dataBit),
    .strobe   (strobe),
    .digitSel (digitSel),
    .seg      (seg)
  );

endmodule

// File: tb/code_cmp_top_tb.sv
module code_cmp_top_tb;

  localparam int         HOLD   = 40;
  localparam logic [4:0] REF    = 5'b11001;
  localparam int         NVEC   = 8;
  localparam logic [6:0] G_ZERO = 7'h40;
  localparam logic [6:0] G_ONE  = 7'h79;
  localparam logic [6:0] G_EQ   = 7'h06;
  localparam logic [6:0] G_NE   = 7'h2B;
  localparam logic [6:0] G_OFF  = 7'h7F;
  localparam logic [4:0] VEC [NVEC] = '{5'b11001, 5'b00000, 5'b11111, 5'b11000,
                                        5'b01001, 5'b11011, 5'b10101, 5'b00110};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dataBit = 1'b0;
  logic       trigger = 1'b0;
  logic [6:0] digitSel;
  logic [6:0] seg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  code_cmp_top #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .dataBit  (dataBit),
    .trigger  (trigger),
    .digitSel (digitSel),
    .seg      (seg)
  );

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkDark(input string req);
    check(req, {digitSel, seg}, {7'h7F, G_OFF});
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // One short press; returns at the negedge right after the capturing edge
  task automatic enterBit(input logic b);
    @(negedge clk);
    dataBit = b;
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  task automatic enterCode(input logic [4:0] code);
    for (int i = 4; i >= 0; i--) enterBit(code[i]);
  endtask

  function automatic logic [6:0] expGlyph(input logic [4:0] code, input int digit);
    if (digit < 5) return code[4-digit] ? G_ONE : G_ZERO;
    if (digit == 5) return (code == REF) ? G_EQ : G_NE;
    return G_OFF;
  endfunction

  // Samples 7 negedges, starting with the current one; ends on the 7th
  task automatic checkShown(input logic [4:0] code, input string req);
    for (int k = 0; k < 7; k++) begin
      int idx = -1;
      int lows = 0;
      if (k > 0) @(negedge clk);
      for (int d = 0; d < 7; d++) if (!digitSel[d]) begin lows++; idx = d; end
      check("R6 one digit per cycle", 14'(lows), 14'(1));
      check("R6 scan order", 14'(idx), 14'(k));
      if (idx >= 0) check(req, {7'h0, seg}, {7'h0, expGlyph(code, idx)});
    end
  endtask

  initial begin
    doReset();
    checkDark("R1 after reset");

    // Table of codes: glyphs, match symbol, hold length
    for (int v = 0; v < NVEC; v++) begin
      enterCode(VEC[v]);
      checkShown(VEC[v], "R3 R4 R5 digit glyph");
      repeat (HOLD - 7) @(negedge clk);
      check("R7 still lit at last hold cycle", 14'(digitSel != 7'h7F), 14'(1));
      @(negedge clk);
      checkDark("R7 dark after hold");
    end

    // Four bits leave the display dark
    for (int i = 4; i >= 1; i--) enterBit(REF[i]);
    repeat (3) @(negedge clk);
    checkDark("R2 dark before fifth bit");
    enterBit(REF[0]);
    checkShown(REF, "R2 fifth bit shows");

    // Presses during the hold are ignored
    for (int i = 0; i < 3; i++) enterBit(1'b0);   // negedges 8..13
    repeat (HOLD - 13) @(negedge clk);
    check("R8 hold not cut", 14'(digitSel != 7'h7F), 14'(1));
    @(negedge clk);
    checkDark("R8 dark after hold");
    for (int i = 4; i >= 1; i--) enterBit(5'b10101 >> i);
    checkDark("R8 hold presses not counted");
    enterBit(1'b1);
    checkShown(5'b10101, "R8 entry after hold");
    repeat (HOLD - 6) @(negedge clk);
    checkDark("R8 return to dark");

    // Long press captures one bit
    @(negedge clk);
    dataBit = 1'b1;
    trigger = 1'b1;
    repeat (6) @(negedge clk);
    trigger = 1'b0;
    enterBit(1'b1);
    enterBit(1'b0);
    enterBit(1'b0);
    checkDark("R9 long press is one bit");
    enterBit(1'b1);
    checkShown(5'b11001, "R9 code after long press");
    repeat (HOLD - 6) @(negedge clk);
    checkDark("R9 return to dark");

    // Reset mid-entry discards partial bits
    enterBit(1'b0);
    enterBit(1'b0);
    doReset();
    checkDark("R1 reset mid entry");
    enterCode(5'b11001);
    checkShown(5'b11001, "R1 clean entry after reset");

    // Reset during hold blanks at once
    doReset();
    checkDark("R10 reset during hold");
    enterCode(5'b01110);
    checkShown(5'b01110, "R10 entry after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule